// File: doc/BRIEF.md
# Legacy Interrupt Register Front End

This block is the byte-wide register face of a cut-down legacy interrupt controller, sitting in a 256-byte I/O window at a parameterised base address. It keeps an 8-bit pending register, a primary enable mask and a secondary mask. It drives one level interrupt toward the chipset. That interrupt is high whenever a pending bit is also enabled.

Device sources set or clear pending bits through side vectors. Software masks sources and acknowledges them one bit index at a time. It also reads a speaker status bit taken from an external timer channel-2 level. Accesses to the timer ports go straight to a timer stub through strobes. The two DMA mode ports are latched and exposed. A group of legacy ports accepts writes and discards them. Every access that is not supported raises a one-cycle error.

Top module: `legacy_irq_regs`

## Requirements
- R1: After reset the pending register is 0, the enable mask is 0 (the primary mask port reads 0xFF), the secondary mask is 0 (its port reads 0xFF), both DMA mode outputs are 0 and `irq` is low.
- R2: A byte write to offset 0x21 stores the inverse of the data as the enable mask. A byte read of 0x21 returns the value last written.
- R3: `irq` is a register equal to the OR of (pending AND enable) as it stands after the cycle's updates. It is visible one clock after the access or side input that changed it.
- R4: A byte write to offset 0x20 clears pending bit number data[3:0]. Indices 8 to 15 clear nothing.
- R5: A bit set in `src_set` sets that pending bit, and a bit set in `src_clr` clears it. When a set and a clear (from `src_clr` or an acknowledge) hit the same bit in the same cycle, the set wins.
- R6: A byte read of 0x20 returns the pending register. An 8-byte read of 0x20 returns it zero-extended to 64 bits. A byte read of 0xA0 returns 0x00.
- R7: A byte write to 0xA1 stores the data unchanged. A byte read of 0xA1 returns its inverse. The secondary mask never affects `irq`.
- R8: A byte read of 0x61 returns 0x20 when `tmr2_out` is high and 0x00 when it is low.
- R9: A legal byte write to 0x40–0x43 pulses `tmr_wr` in the access cycle, with `tmr_sel` = offset[1:0] and `tmr_wdata` = data. A legal byte read of 0x40–0x42 pulses `tmr_rd` and returns `tmr_rdata` as sampled in that cycle.
- R10: Byte writes to 0x0B and 0xD6 latch the data onto `dma_mode_a` and `dma_mode_b`. Byte writes to 0x08, 0x0A, 0x0D, 0x0F, 0xD0, 0xD4, 0xDA, 0xDE, 0xA0, 0x61 and 0x64 are accepted and change nothing.
- R11: The following accesses are illegal: an address outside [BASE, BASE+0x100), an undecoded offset, any write wider than one byte, and any read wider than one byte except an 8-byte read at 0x20. Size codes are 0=1, 1=2, 2=4 and 3=8 bytes. An illegal access pulses `acc_err`, returns zero read data and leaves all state unchanged.
- R12: `acc_rdata` and `acc_err` are registered and valid in the cycle after the access. With no access they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Full access address |
| acc_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 64 | Read data, one cycle later |
| acc_err | output | 1 | Illegal access flag, one cycle later |
| src_set | input | 8 | Pending bits to set |
| src_clr | input | 8 | Pending bits to clear |
| tmr2_out | input | 1 | Timer channel-2 output level |
| tmr_wr | output | 1 | Timer port write strobe |
| tmr_rd | output | 1 | Timer port read strobe |
| tmr_sel | output | 2 | Timer port select (offset bits 1:0) |
| tmr_wdata | output | 8 | Timer write data |
| tmr_rdata | input | 8 | Timer read data, same cycle as `tmr_rd` |
| dma_mode_a | output | 8 | Latched first DMA mode |
| dma_mode_b | output | 8 | Latched second DMA mode |
| irq | output | 1 | Level interrupt to the chipset |

## Verification
Read data, the error flag and `irq` all come from registers that load on the edge that ends the access cycle. The bench drives each access on a falling edge and reads these outputs on the next falling edge, one full cycle later. The timer strobes are combinational, so the bench samples them one nanosecond after driving the access, before the capturing edge. Side-input updates follow the same one-cycle rule. The bench keeps an arithmetic model of pending, enable and the secondary mask and sweeps every offset, mask value and acknowledge index against it.

// File: rtl/legacy_irq_regs.sv
module legacy_irq_regs #(
  parameter int              ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h0400,
  parameter logic [7:0]      SPK_HI = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [7:0]        acc_wdata,
  output logic [63:0]       acc_rdata,
  output logic              acc_err,
  input  logic [7:0]        src_set,
  input  logic [7:0]        src_clr,
  input  logic              tmr2_out,
  output logic              tmr_wr,
  output logic              tmr_rd,
  output logic [1:0]        tmr_sel,
  output logic [7:0]        tmr_wdata,
  input  logic [7:0]        tmr_rdata,
  output logic [7:0]        dma_mode_a,
  output logic [7:0]        dma_mode_b,
  output logic              irq
);
  localparam int OFF_W = 8;

  logic [ADDR_W-1:0] off_full;
  logic [OFF_W-1:0]  off;
  logic in_win, rd_dec, wr_dec, legal_rd, legal_wr, rd_fire, wr_fire, bad;
  logic [7:0] pend_q, en_q, m2_q, rd_mux, ack_mask, pend_n, en_n;

  assign off_full = acc_addr - BASE;
  assign off      = off_full[OFF_W-1:0];
  assign in_win   = (acc_addr >= BASE) && (off_full[ADDR_W-1:OFF_W] == '0);

  always_comb begin
    case (off)
      8'h20, 8'h21, 8'hA0, 8'hA1, 8'h40, 8'h41, 8'h42, 8'h61: rd_dec = 1'b1;
      default: rd_dec = 1'b0;
    endcase
    case (off)
      8'h20, 8'h21, 8'hA1, 8'h0B, 8'hD6, 8'h40, 8'h41, 8'h42, 8'h43,
      8'h08, 8'h0A, 8'h0D, 8'h0F, 8'hD0, 8'hD4, 8'hDA, 8'hDE,
      8'hA0, 8'h61, 8'h64: wr_dec = 1'b1;
      default: wr_dec = 1'b0;
    endcase
    case (off)
      8'h20:                rd_mux = pend_q;
      8'h21:                rd_mux = ~en_q;
      8'hA1:                rd_mux = ~m2_q;
      8'h40, 8'h41, 8'h42:  rd_mux = tmr_rdata;
      8'h61:                rd_mux = tmr2_out ? SPK_HI : 8'h00;
      default:              rd_mux = 8'h00;
    endcase
  end

  assign legal_rd = in_win && (((acc_size == 2'd0) && rd_dec) ||
                               ((acc_size == 2'd3) && (off == 8'h20)));
  assign legal_wr = in_win && (acc_size == 2'd0) && wr_dec;
  assign rd_fire  = acc_valid && !acc_write && legal_rd;
  assign wr_fire  = acc_valid &&  acc_write && legal_wr;
  assign bad      = acc_valid && !(acc_write ? legal_wr : legal_rd);

  assign tmr_wr    = wr_fire && (off[7:2] == 6'h10);
  assign tmr_rd    = rd_fire && (off[7:2] == 6'h10) && (off[1:0] != 2'd3);
  assign tmr_sel   = off[1:0];
  assign tmr_wdata = acc_wdata;

  assign ack_mask = (wr_fire && off == 8'h20 && !acc_wdata[3]) ? (8'h01 << acc_wdata[2:0]) : 8'h00;
  assign pend_n   = (pend_q & ~src_clr & ~ack_mask) | src_set;
  assign en_n     = (wr_fire && off == 8'h21) ? ~acc_wdata : en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      en_q       <= '0;
      m2_q       <= '0;
      dma_mode_a <= '0;
      dma_mode_b <= '0;
      irq        <= 1'b0;
      acc_rdata  <= '0;
      acc_err    <= 1'b0;
    end else begin
      pend_q    <= pend_n;
      en_q      <= en_n;
      irq       <= |(pend_n & en_n);
      acc_err   <= bad;
      acc_rdata <= rd_fire ? {56'b0, rd_mux} : 64'b0;
      if (wr_fire && off == 8'hA1) m2_q       <= acc_wdata;
      if (wr_fire && off == 8'h0B) dma_mode_a <= acc_wdata;
      if (wr_fire && off == 8'hD6) dma_mode_b <= acc_wdata;
    end
  end
endmodule

// File: rtl/legacy_irq_regs_chk.sv
module legacy_irq_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic [7:0]  src_set,
  input logic [7:0]  src_clr,
  input logic [7:0]  pend_q,
  input logic [7:0]  en_q,
  input logic        irq,
  input logic        acc_err,
  input logic [63:0] acc_rdata,
  input logic        tmr_wr,
  input logic        tmr_rd
);
  p_err_zero_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> acc_rdata == 64'b0);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!acc_err && acc_rdata == 64'b0));
  p_set_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && (src_set & en_q) != 8'h00) |=> irq);
  p_masked_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && en_q == 8'h00) |=> !irq);
  p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && src_set == 8'h00 && ((pend_q & en_q & ~src_clr) == 8'h00)) |=> !irq);
  p_strobe_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_wr || tmr_rd) |-> (acc_valid && !(tmr_wr && tmr_rd)));
endmodule

bind legacy_irq_regs legacy_irq_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .src_set(src_set),
  .src_clr(src_clr), .pend_q(pend_q), .en_q(en_q), .irq(irq),
  .acc_err(acc_err), .acc_rdata(acc_rdata), .tmr_wr(tmr_wr), .tmr_rd(tmr_rd)
);

// File: tb/test_legacy_irq_regs.sv
module test_legacy_irq_regs;
  localparam logic [15:0] BASE = 16'h0400;
  logic clk = 0, rst_n = 0, acc_valid = 0, acc_write = 0, tmr2_out = 0;
  logic [15:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [7:0]  acc_wdata = '0, src_set = '0, src_clr = '0, tmr_rdata = 8'h5A;
  logic [63:0] acc_rdata;
  logic acc_err, tmr_wr, tmr_rd, irq;
  logic [1:0] tmr_sel;
  logic [7:0] tmr_wdata, dma_mode_a, dma_mode_b;
  int total = 0, bad = 0;
  logic [7:0] m_pend = 0, m_en = 0, m_m2 = 0, m_da = 0, m_db = 0;

  always #5 clk = ~clk;

  legacy_irq_regs i_legacy_irq_regs (.*);

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic bit rd_known(int o);
    return o == 'h20 || o == 'h21 || o == 'hA0 || o == 'hA1 ||
           o == 'h40 || o == 'h41 || o == 'h42 || o == 'h61;
  endfunction
  function automatic bit wr_known(int o);
    return o == 'h20 || o == 'h21 || o == 'hA1 || o == 'h0B || o == 'hD6 ||
           (o >= 'h40 && o <= 'h43) || o == 'h08 || o == 'h0A || o == 'h0D ||
           o == 'h0F || o == 'hD0 || o == 'hD4 || o == 'hDA || o == 'hDE ||
           o == 'hA0 || o == 'h61 || o == 'h64;
  endfunction
  function automatic logic [7:0] rd_val(int o);
    case (o)
      'h20: return m_pend;
      'h21: return ~m_en;
      'hA1: return ~m_m2;
      'h40, 'h41, 'h42: return tmr_rdata;
      'h61: return tmr2_out ? 8'h20 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic op(string r, bit w, logic [15:0] a, logic [1:0] sz, logic [7:0] d,
                    logic [7:0] st = 0, logic [7:0] cl = 0);
    int  o = int'(a - BASE);
    bit  inw = (a >= BASE) && (a < BASE + 16'h100);
    bit  ok = inw && (w ? (sz == 0 && wr_known(o)) :
                          ((sz == 0 && rd_known(o)) || (sz == 3 && o == 'h20)));
    logic [63:0] erd = (!w && ok) ? {56'b0, rd_val(o)} : 64'b0;
    logic [7:0] ack = 0;
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_addr = a; acc_size = sz; acc_wdata = d;
    src_set = st; src_clr = cl;
    #1;
    chk({r, " tmr_wr"}, tmr_wr, w && ok && o >= 'h40 && o <= 'h43);
    chk({r, " tmr_rd"}, tmr_rd, !w && ok && o >= 'h40 && o <= 'h42);
    if (w && ok && o >= 'h40 && o <= 'h43) begin
      chk({r, " tmr_sel"}, tmr_sel, o[1:0]);
      chk({r, " tmr_wdata"}, tmr_wdata, d);
    end
    if (w && ok) begin
      if (o == 'h21) m_en = ~d;
      if (o == 'hA1) m_m2 = d;
      if (o == 'h0B) m_da = d;
      if (o == 'hD6) m_db = d;
      if (o == 'h20 && !d[3]) ack = 8'h01 << d[2:0];
    end
    m_pend = (m_pend & ~cl & ~ack) | st;
    @(negedge clk);
    chk({r, " err"}, acc_err, !ok);
    chk({r, " rdata"}, acc_rdata, erd);
    chk({r, " irq"}, irq, |(m_pend & m_en));
    acc_valid = 0; src_set = 0; src_clr = 0;
  endtask

  task automatic side(string r, logic [7:0] st, logic [7:0] cl);
    @(negedge clk);
    src_set = st; src_clr = cl;
    m_pend = (m_pend & ~cl) | st;
    @(negedge clk);
    chk({r, " irq"}, irq, |(m_pend & m_en));
    src_set = 0; src_clr = 0;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 dma_a", dma_mode_a, 0);
    chk("R1 dma_b", dma_mode_b, 0);
    op("R1 mask", 0, BASE + 'h21, 0, 0);
    chk("R1 mask val", acc_rdata, 64'hFF);
    op("R1 m2", 0, BASE + 'hA1, 0, 0);
    chk("R1 m2 val", acc_rdata, 64'hFF);
    op("R1 pend", 0, BASE + 'h20, 0, 0);
    // R6 R7 R8 R9 R11: byte read sweep over every offset
    tmr2_out = 1;
    for (int o = 0; o < 256; o++) op("R11 rd sweep", 0, BASE + 16'(o), 0, 0);
    tmr2_out = 0;
    op("R8 portb low", 0, BASE + 'h61, 0, 0);
    // R5 R3: side inputs with all enabled
    op("R2 mask all", 1, BASE + 'h21, 0, 8'h00);
    side("R5 set", 8'h81, 0);
    side("R5 clr", 0, 8'h01);
    side("R5 clr all", 0, 8'h80);
    side("R5 set wins", 8'h10, 8'h10);
    // R2 R3: mask sweep with a fixed pending pattern
    side("R5 pattern", 8'h5A, 8'hA5);
    for (int m = 0; m < 256; m++) begin
      op("R2 mask wr", 1, BASE + 'h21, 0, 8'(m));
      op("R2 mask rd", 0, BASE + 'h21, 0, 0);
    end
    // R4: acknowledge every index from a full pending register
    op("R2 mask open", 1, BASE + 'h21, 0, 8'h00);
    for (int i = 0; i < 16; i++) begin
      side("R4 fill", 8'hFF, 0);
      op("R4 ack", 1, BASE + 'h20, 0, 8'(i) | 8'hF0);
      op("R4 pend", 0, BASE + 'h20, 0, 0);
    end
    side("R4 drain", 0, 8'hFF);
    side("R4 one", 8'h04, 0);
    op("R4 last ack drops irq", 1, BASE + 'h20, 0, 8'h02);
    side("R5 refill", 8'h08, 0);
    op("R5 set beats ack", 1, BASE + 'h20, 0, 8'h03, 8'h08, 0);
    // R6: wide reads
    op("R6 wide pend", 0, BASE + 'h20, 3, 0);
    op("R11 wide mask", 0, BASE + 'h21, 3, 0);
    op("R11 half pend", 0, BASE + 'h20, 1, 0);
    op("R11 word pend", 0, BASE + 'h20, 2, 0);
    op("R11 wide write", 1, BASE + 'h21, 3, 8'hFF);
    op("R11 half write", 1, BASE + 'h0B, 1, 8'h77);
    op("R11 below win", 0, BASE - 1, 0, 0);
    op("R11 above win", 1, BASE + 'h100, 0, 8'hFF);
    // R7: secondary mask has no irq effect
    op("R7 m2 wr", 1, BASE + 'hA1, 0, 8'h00);
    op("R7 m2 rd", 0, BASE + 'hA1, 0, 0);
    op("R7 m2 wr2", 1, BASE + 'hA1, 0, 8'hC3);
    op("R7 m2 rd2", 0, BASE + 'hA1, 0, 0);
    // R10: DMA modes, then write sweep (ignored ports and errors)
    op("R10 mode a", 1, BASE + 'h0B, 0, 8'h3C);
    op("R10 mode b", 1, BASE + 'hD6, 0, 8'hC5);
    chk("R10 dma_a", dma_mode_a, m_da);
    chk("R10 dma_b", dma_mode_b, m_db);
    for (int o = 0; o < 256; o++) begin
      op("R10 wr sweep", 1, BASE + 16'(o), 0, 8'hFE);
      chk("R10 dma_a sweep", dma_mode_a, m_da);
      chk("R10 dma_b sweep", dma_mode_b, m_db);
    end
    op("R10 pend after sweep", 0, BASE + 'h20, 0, 0);
    op("R10 mask after sweep", 0, BASE + 'h21, 0, 0);
    op("R10 m2 after sweep", 0, BASE + 'hA1, 0, 0);
    // R12: idle outputs
    @(negedge clk);
    chk("R12 idle err", acc_err, 0);
    chk("R12 idle rdata", acc_rdata, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule